// File: doc/BRIEF.md
# Serial Shift Unit with Bit-Order Select

This block is the data path of a clocked synchronous serial port. Software places up to four transmit bytes on `tx_data_i` and picks a length code and a bit order. A start pulse then begins a transfer. One internal byte-wide shift register both sends and receives. Its bit 0 always drives the serial output, and it always shifts toward bit 0. Each new serial input bit enters at the top, so after eight shifts the first received bit sits in bit 0.

The bit order is set by reversing bytes where they cross between the shift register and the data registers. In MSB-first mode, each transmit byte is reversed when it is loaded and each received byte is reversed when it is stored. The shift logic is the same for both orders. Bytes are handled in index order: byte 0 goes first, and received byte k lands in receive slot k. The length code also sets which receive slots are flagged valid.

The serial clock is generated outside the block and arrives as two single-cycle strobes, one per edge. The serial output changes on the falling strobe. The serial input is sampled on the rising strobe.

Top module: `ssu_shift_path`

## Requirements
- R1: After reset, `sdo_o`, `busy_o` and `done_o` are 0, and `rx_data_o` and `rx_valid_o` are all zeros.
- R2: With `msb_first_i`=0, each transmit byte k (`tx_data_i[8k+7:8k]`) is sent starting with its bit 0 and ending with its bit 7.
- R3: With `msb_first_i`=1, each transmit byte is sent starting with its bit 7 and ending with its bit 0.
- R4: The first bit of a transfer is on `sdo_o` in the cycle after the accepted start. During a transfer, `sdo_o` changes only in the cycle after a `sck_fall_i` strobe.
- R5: `sdi_i` is sampled when `sck_rise_i` is high. With LSB-first order, the first bit received for a byte lands in bit 0 of that byte's receive slot.
- R6: With MSB-first order, the first bit received for a byte lands in bit 7 of its receive slot.
- R7: Bytes are handled in index order from 0 upward. Received byte k is written to `rx_data_o[8k+7:8k]` in the cycle after the eighth falling strobe of that byte. Slots that the transfer does not reach keep their contents.
- R8: Length code 00 transfers 1 byte, code 01 transfers 2 bytes and code 10 transfers 4 bytes. At the end of a transfer, `rx_valid_o` becomes 0001, 0011 or 1111 respectively. An accepted start clears `rx_valid_o` to 0000.
- R9: A start with length code 11 is rejected. `busy_o` and `done_o` stay 0, and `sdo_o` and `rx_data_o` do not change. Serial strobes while idle have no effect.
- R10: `done_o` is a single-cycle pulse in the cycle after the final falling strobe. `busy_o` drops in that same cycle.
- R11: A start pulse while `busy_o` is high is ignored. The running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to begin a transfer |
| msb_first_i | input | 1 | 0 = LSB first, 1 = MSB first; latched at start |
| len_code_i | input | 2 | 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = rejected |
| tx_data_i | input | 32 | Four transmit bytes, byte k at bits 8k+7:8k |
| sck_rise_i | input | 1 | Strobe for the serial-clock edge that samples input |
| sck_fall_i | input | 1 | Strobe for the serial-clock edge that shifts output |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | 32 | Four receive slots, slot k at bits 8k+7:8k |
| rx_valid_o | output | 4 | Valid flag per receive slot |

## Verification
Every result of this block is one register away from its cause:
- The first output bit, `busy_o` and the cleared valid mask appear one cycle after the start.
- Each new output bit appears one cycle after a falling strobe.
- A received byte, `done_o` and the valid mask appear one cycle after the eighth falling strobe of the byte concerned.

The bench changes inputs on the falling clock edge, so each strobe is seen at exactly one rising edge. It checks results at the next falling edge, which is the first point where they are due. It also checks `sdo_o` in an idle cycle placed between the rising and falling strobes. This shows the output holds until the shift edge.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    LEN_8   = 2'b00,
    LEN_16  = 2'b01,
    LEN_32  = 2'b10,
    LEN_BAD = 2'b11
  } len_code_e;
endpackage

// File: rtl/ssu_bit_order.sv
module ssu_bit_order #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         rev_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] rev;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign rev[g] = data_i[W-1-g];
  end

  assign data_o = rev_i ? rev : data_i;
endmodule

// File: rtl/ssu_shift_ctrl.sv
module ssu_shift_ctrl
  import ssu_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_BYTES = 4,
  localparam int unsigned IDX_W  = $clog2(N_BYTES),
  localparam int unsigned CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              msb_first_i,
  input  logic [1:0]        len_code_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] tx_ordered_i,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic              tx_rev_o,
  output logic [BYTE_W-1:0] rx_raw_o,
  output logic              rx_we_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic              msb_o,
  output logic [1:0]        len_o,
  output logic              start_ok_o,
  output logic              final_o,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [BYTE_W-1:0] sreg_q, shifted;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  byte_idx_q, last_q, last_d;
  logic              busy_q, done_q, msb_q, rx_bit_q;
  logic [1:0]        len_q;
  logic              load_first, byte_end, is_last, load_next;

  always_comb begin
    case (len_code_i)
      LEN_8:   last_d = '0;
      LEN_16:  last_d = IDX_W'(1);
      default: last_d = IDX_W'(N_BYTES - 1);
    endcase
  end

  assign load_first = start_i & ~busy_q & (len_code_i != LEN_BAD);
  assign byte_end   = busy_q & sck_fall_i & (bit_cnt_q == CNT_W'(BYTE_W - 1));
  assign is_last    = (byte_idx_q == last_q);
  assign load_next  = byte_end & ~is_last;
  // serial in enters at the top; output always from bit 0
  assign shifted    = {rx_bit_q, sreg_q[BYTE_W-1:1]};

  assign tx_idx_o   = load_first ? '0 : byte_idx_q + IDX_W'(1);
  assign tx_rev_o   = load_first ? msb_first_i : msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q     <= '0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      last_q     <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      msb_q      <= 1'b0;
      len_q      <= 2'b00;
      rx_bit_q   <= 1'b0;
    end else begin
      done_q <= byte_end & is_last;
      if (busy_q && sck_rise_i) rx_bit_q <= sdi_i;
      if (load_first) begin
        sreg_q     <= tx_ordered_i;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        last_q     <= last_d;
        msb_q      <= msb_first_i;
        len_q      <= len_code_i;
        busy_q     <= 1'b1;
      end else if (load_next) begin
        sreg_q     <= tx_ordered_i;
        bit_cnt_q  <= '0;
        byte_idx_q <= byte_idx_q + IDX_W'(1);
      end else if (byte_end) begin
        sreg_q     <= shifted;
        bit_cnt_q  <= '0;
        busy_q     <= 1'b0;
      end else if (busy_q && sck_fall_i) begin
        sreg_q     <= shifted;
        bit_cnt_q  <= bit_cnt_q + CNT_W'(1);
      end
    end
  end

  assign rx_raw_o   = shifted;
  assign rx_we_o    = byte_end;
  assign rx_idx_o   = byte_idx_q;
  assign msb_o      = msb_q;
  assign len_o      = len_q;
  assign start_ok_o = load_first;
  assign final_o    = byte_end & is_last;
  assign sdo_o      = sreg_q[0];
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  assert_bad_len_rejected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && len_code_i == LEN_BAD) |=> !busy_q);

  assert_sdo_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !sck_fall_i) |=> $stable(sdo_o));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  assert_start_ignored_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !sck_fall_i) |=> (busy_q && $stable(byte_idx_q) && $stable(msb_q)));
endmodule

// File: rtl/ssu_rx_bank.sv
module ssu_rx_bank
  import ssu_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_BYTES = 4,
  localparam int unsigned IDX_W  = $clog2(N_BYTES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [BYTE_W-1:0]         byte_i,
  input  logic                      clr_i,
  input  logic                      set_i,
  input  logic [1:0]                len_i,
  output logic [N_BYTES*BYTE_W-1:0] data_o,
  output logic [N_BYTES-1:0]        valid_o
);
  logic [N_BYTES-1:0] valid_q, mask;

  always_comb begin
    case (len_i)
      LEN_8:   mask = N_BYTES'(1);
      LEN_16:  mask = N_BYTES'(3);
      default: mask = '1;
    endcase
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            slot_q <= '0;
      else if (we_i && idx_i == IDX_W'(g))    slot_q <= byte_i;
    end
    assign data_o[g*BYTE_W +: BYTE_W] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= '0;
    else if (clr_i)  valid_q <= '0;
    else if (set_i)  valid_q <= mask;
  end

  assign valid_o = valid_q;

  assert_valid_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0) || (valid_q == N_BYTES'(1)) || (valid_q == N_BYTES'(3)) || (valid_q == '1));

  assert_valid_only_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0 && !set_i) |=> (valid_q == '0));
endmodule

// File: rtl/ssu_shift_path.sv
module ssu_shift_path
  import ssu_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned N_BYTES = 4,
  localparam int unsigned IDX_W  = $clog2(N_BYTES),
  localparam int unsigned DATA_W = BYTE_W * N_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              msb_first_i,
  input  logic [1:0]        len_code_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [N_BYTES-1:0] rx_valid_o
);
  logic [BYTE_W-1:0] tx_bytes [N_BYTES];
  logic [BYTE_W-1:0] tx_ordered, rx_raw, rx_ordered;
  logic [IDX_W-1:0]  tx_idx, rx_idx;
  logic              tx_rev, rx_we, msb, start_ok, final_ev;
  logic [1:0]        len;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_tx
    assign tx_bytes[g] = tx_data_i[g*BYTE_W +: BYTE_W];
  end

  ssu_bit_order #(.W(BYTE_W)) u_tx_order (
    .data_i (tx_bytes[tx_idx]),
    .rev_i  (tx_rev),
    .data_o (tx_ordered)
  );

  ssu_shift_ctrl #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .msb_first_i  (msb_first_i),
    .len_code_i   (len_code_i),
    .sck_rise_i   (sck_rise_i),
    .sck_fall_i   (sck_fall_i),
    .sdi_i        (sdi_i),
    .tx_ordered_i (tx_ordered),
    .tx_idx_o     (tx_idx),
    .tx_rev_o     (tx_rev),
    .rx_raw_o     (rx_raw),
    .rx_we_o      (rx_we),
    .rx_idx_o     (rx_idx),
    .msb_o        (msb),
    .len_o        (len),
    .start_ok_o   (start_ok),
    .final_o      (final_ev),
    .sdo_o        (sdo_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  ssu_bit_order #(.W(BYTE_W)) u_rx_order (
    .data_i (rx_raw),
    .rev_i  (msb),
    .data_o (rx_ordered)
  );

  ssu_rx_bank #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_rx_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rx_we),
    .idx_i   (rx_idx),
    .byte_i  (rx_ordered),
    .clr_i   (start_ok),
    .set_i   (final_ev),
    .len_i   (len),
    .data_o  (rx_data_o),
    .valid_o (rx_valid_o)
  );
endmodule

// File: tb/ssu_shift_path_tb.sv
`timescale 1ns/1ps
module ssu_shift_path_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, msb_first = 1'b0, sck_rise = 1'b0, sck_fall = 1'b0, sdi = 1'b0;
  logic [1:0]  len_code = 2'b00;
  logic [31:0] tx_data = '0;
  logic        sdo, busy, done;
  logic [31:0] rx_data;
  logic [3:0]  rx_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] exp_rx [4];

  always #2 clk = ~clk;

  ssu_shift_path u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msb_first_i(msb_first),
    .len_code_i(len_code), .tx_data_i(tx_data), .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall), .sdi_i(sdi), .sdo_o(sdo), .busy_o(busy),
    .done_o(done), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check_rx_all(input string req);
    for (int k = 0; k < 4; k++)
      chk(rx_data[8*k +: 8] == exp_rx[k], req, rx_data[8*k +: 8], exp_rx[k]);
  endtask

  // one transfer; rxw bit 8k+i is the i-th bit driven on sdi for byte k
  task automatic run_xfer(input logic msb, input logic [1:0] code, input logic [31:0] txw,
                          input logic [31:0] rxw, input bit poke_start);
    int nb;
    logic [3:0] mask;
    nb   = (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
    mask = (code == 2'b00) ? 4'b0001 : (code == 2'b01) ? 4'b0011 : 4'b1111;
    msb_first = msb; len_code = code; tx_data = txw; start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R4 busy after start", 32'(busy), 1);
    chk(rx_valid == 4'b0, "R8 valid cleared at start", 32'(rx_valid), 0);
    for (int k = 0; k < nb; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic exp_bit;
        exp_bit = msb ? txw[8*k + 7 - i] : txw[8*k + i];
        chk(sdo == exp_bit, msb ? "R3 msb-first tx bit" : "R2 lsb-first tx bit", 32'(sdo), 32'(exp_bit));
        sdi = rxw[8*k + i]; sck_rise = 1'b1;
        tick();
        sck_rise = 1'b0;
        if (poke_start && k == 0 && i == 3) begin
          start = 1'b1; msb_first = ~msb; len_code = 2'b00; tx_data = ~txw;
        end
        tick();
        start = 1'b0; msb_first = msb; len_code = code; tx_data = txw;
        chk(sdo == exp_bit, "R4 sdo holds until fall", 32'(sdo), 32'(exp_bit));
        if (poke_start && k == 0 && i == 3)
          chk(busy == 1'b1, "R11 start while busy ignored", 32'(busy), 1);
        sck_fall = 1'b1;
        tick();
        sck_fall = 1'b0;
      end
      exp_rx[k] = msb ? rev8(rxw[8*k +: 8]) : rxw[8*k +: 8];
      chk(rx_data[8*k +: 8] == exp_rx[k], msb ? "R6/R7 rx byte" : "R5/R7 rx byte",
          rx_data[8*k +: 8], exp_rx[k]);
      if (k < nb - 1)
        chk(busy == 1'b1 && done == 1'b0, "R7 busy between bytes", {busy, done}, 2'b10);
    end
    chk(done == 1'b1, "R10 done after last fall", 32'(done), 1);
    chk(busy == 1'b0, "R10 busy drops with done", 32'(busy), 0);
    chk(rx_valid == mask, "R8 valid mask", 32'(rx_valid), 32'(mask));
    check_rx_all("R7 untouched slots keep value");
    tick();
    chk(done == 1'b0, "R10 done single cycle", 32'(done), 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        finished = 1'b1;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) exp_rx[k] = 8'h00;
    tick(); tick();
    chk(sdo == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs", {sdo, busy, done}, 0);
    chk(rx_data == 32'h0 && rx_valid == 4'h0, "R1 reset rx", rx_data, 0);
    rst_n = 1'b1;
    tick();

    // near-exhaustive 8-bit sweep, both orders
    for (int v = 0; v < 256; v++) begin
      run_xfer(1'b0, 2'b00, {24'h5a3c96, 8'(v)}, {24'h0, 8'((v * 37 + 11) & 255)}, 1'b0);
      run_xfer(1'b1, 2'b00, {24'hc3a51e, 8'(v)}, {24'h0, 8'((v * 91 + 7) & 255)}, 1'b0);
    end
    // 16- and 32-bit transfers
    for (int p = 0; p < 6; p++) begin
      logic [31:0] a, b;
      a = 32'h1234_5678 * 32'(p + 1) + 32'h9e37_79b9;
      b = 32'hdead_beef ^ (32'h0101_0101 * 32'(p * 29 + 3));
      run_xfer(p[0], 2'b01, a, b, 1'b0);
      run_xfer(p[0], 2'b10, b, a, p == 2);
    end

    // R9: rejected length and idle strobes
    begin
      logic s0;
      logic [31:0] r0;
      s0 = sdo; r0 = rx_data;
      msb_first = 1'b0; len_code = 2'b11; tx_data = 32'hffff_ffff; start = 1'b1;
      tick();
      start = 1'b0;
      chk(busy == 1'b0, "R9 len 11 no busy", 32'(busy), 0);
      chk(sdo == s0, "R9 len 11 sdo unchanged", 32'(sdo), 32'(s0));
      for (int j = 0; j < 4; j++) begin
        sdi = ~sdi; sck_rise = 1'b1; tick(); sck_rise = 1'b0;
        sck_fall = 1'b1; tick(); sck_fall = 1'b0;
        chk(done == 1'b0 && busy == 1'b0, "R9 no transfer started", {busy, done}, 0);
        chk(sdo == s0, "R9 idle strobes leave sdo", 32'(sdo), 32'(s0));
      end
      chk(rx_data == r0, "R9 rx unchanged", rx_data, r0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule